// File: doc/BRIEF.md
# Translation Cache with Line Shoot-Down

This block is a small, fully associative cache of second-level page table entries. It sits in front of an address translator. The translator presents a virtual page number on the lookup port. One cycle later the block reports hit or miss, together with the cached entry. Each lookup also raises exactly one hit pulse or one miss pulse, which drives the statistics counters. When a lookup misses, the page walker resolves the entry and installs it through the fill port. Slots are chosen in round-robin order. A fill whose page is already cached rewrites that slot in place.

The block offers two ways to invalidate entries. A full clear is a one-cycle operation, and a busy flag is raised for its duration. A targeted shoot-down is started through a single memory-mapped register. Software writes a line address with the start bit set. The block then walks every slot, one per cycle, and drops each entry whose page falls in the aligned group of four pages. The busy bit in the register stays set until the walk finishes, and software polls it before issuing the next line. While the walk runs, the line being invalidated is fenced: lookups into it miss and fills into it are discarded.

Top module: `tlb_shootdown`

## Requirements
- R1: After reset no lookup hits, both pulse outputs and `clr_busy` are low, and reading byte offset 0x18 returns zero.
- R2: A lookup presented in cycle n reports `lk_hit`, `lk_entry` (zero on miss) and exactly one of `stat_hit`/`stat_miss` in cycle n+1. A cycle without a lookup produces neither pulse.
- R3: Fills of new pages take slots in round-robin order, so after ENTRIES distinct fills the next new page evicts the oldest of them.
- R4: A fill whose page is already cached replaces that slot's entry and does not advance the round-robin pointer.
- R5: A write to byte offset 0x18 with bit 30 set, issued while idle, starts a shoot-down. On reads of offset 0x18, bit 31 is busy and bits [VPN_W-1:0] give the latched line's page number with its two low bits forced to zero. Busy stays set for exactly ENTRIES cycles.
- R6: A shoot-down invalidates every cached page whose number, with the two low bits dropped, equals the latched line, and leaves all other pages cached.
- R7: While a shoot-down is busy, a lookup into its line reports a miss, even if the matching slot has not yet been scanned.
- R8: While a shoot-down is busy, a fill into its line is dropped and a fill into any other line is accepted.
- R9: The following writes leave the line and busy state untouched: a register write while a shoot-down is busy, a write to offset 0x18 without bit 30, and a write to any other offset.
- R10: A `clr_start` pulse while idle raises `clr_busy` for exactly one cycle, after which every page misses. In that busy cycle, lookups miss, fills are dropped and a further `clr_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_hit | output | 1 | Lookup hit, one cycle after the request |
| lk_entry | output | DATA_W | Cached entry on hit, zero on miss |
| stat_hit | output | 1 | One-cycle pulse per hitting lookup |
| stat_miss | output | 1 | One-cycle pulse per missing lookup |
| fill_valid | input | 1 | Install request from the walker |
| fill_vpn | input | VPN_W | Page number of the installed entry |
| fill_entry | input | DATA_W | Entry to install |
| clr_start | input | 1 | Start a full clear |
| clr_busy | output | 1 | Full clear in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench aims lookups at a line whose shoot-down has just begun, before the matching slot has been scanned. A design that only clears valid bits as the scan reaches them would return stale hits there. It fills a cache that is full and then refreshes a resident page. A pointer that advances on refills would then evict the wrong victim. It writes the register while a shoot-down is busy and counts the busy cycles. A design that accepts such a write would retarget the line or stretch the walk, which shows up in the read-back page number and in the busy length. It also sends an unaligned line address, overlaps fills and lookups with a full clear, and checks the neighbouring lines. This catches a mask that drops the wrong low bits, or a fill that slips in during a clear.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // Byte offset of the shoot-down control register
    localparam logic [7:0] SD_OFFSET    = 8'h18;
    // Write: start an invalidation of one line
    localparam int         SD_START_BIT = 30;
    // Read: invalidation still scanning
    localparam int         SD_BUSY_BIT  = 31;
    // A line is 2**LINE_SHIFT consecutive pages
    localparam int         LINE_SHIFT   = 2;
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
            else                             ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/tlb_shoot_ctl.sv
module tlb_shoot_ctl import tlb_pkg::*; #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int LINE_W = VPN_W - LINE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy,
    output logic [LINE_W-1:0] line,
    output logic [IDX_W-1:0]  idx
);
    typedef struct packed {
        logic              busy;
        logic [LINE_W-1:0] line;
        logic [IDX_W-1:0]  idx;
    } sd_state_t;

    sd_state_t st_d, st_q;
    logic      sel;
    logic      go;

    assign sel = (reg_addr == ADDR_W'(SD_OFFSET));
    assign go  = reg_wr && sel && reg_wdata[SD_START_BIT] && !st_q.busy;

    always_comb begin
        st_d = st_q;
        if (go) begin
            st_d.busy = 1'b1;
            st_d.line = reg_wdata[VPN_W-1:LINE_SHIFT];
            st_d.idx  = '0;
        end else if (st_q.busy) begin
            if (st_q.idx == IDX_W'(ENTRIES - 1)) st_d.busy = 1'b0;
            else                                st_d.idx  = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (sel) begin
            reg_rdata[SD_BUSY_BIT]          = st_q.busy;
            reg_rdata[VPN_W-1:LINE_SHIFT]   = st_q.line;
        end
    end

    assign busy = st_q.busy;
    assign line = st_q.line;
    assign idx  = st_q.idx;
endmodule

// File: rtl/tlb_shootdown.sv
module tlb_shootdown import tlb_pkg::*; #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_entry,
    output logic              stat_hit,
    output logic              stat_miss,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [DATA_W-1:0] fill_entry,
    input  logic              clr_start,
    output logic              clr_busy,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int LINE_W = VPN_W - LINE_SHIFT;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][VPN_W-1:0]  tag;
        logic [ENTRIES-1:0][DATA_W-1:0] data;
        logic                           hit;
        logic [DATA_W-1:0]              entry;
        logic                           s_hit;
        logic                           s_miss;
        logic                           clr_busy;
    } tlb_state_t;

    tlb_state_t        st_d, st_q;
    logic [ENTRIES-1:0] lk_match, fill_match;
    logic              sd_busy;
    logic [LINE_W-1:0] sd_line;
    logic [IDX_W-1:0]  sd_idx;
    logic [IDX_W-1:0]  victim;
    logic              victim_adv;
    logic [DATA_W-1:0] lk_sel;
    logic              lk_fenced, fill_fenced, lk_any, fill_ok;

    tlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .valid(st_q.valid), .tags(st_q.tag), .key(lk_vpn), .match(lk_match)
    );

    tlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
        .valid(st_q.valid), .tags(st_q.tag), .key(fill_vpn), .match(fill_match)
    );

    tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
        .clk(clk), .rst_n(rst_n), .adv(victim_adv), .ptr(victim)
    );

    tlb_shoot_ctl #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ADDR_W(ADDR_W)) u_sd (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(sd_busy), .line(sd_line), .idx(sd_idx)
    );

    // Lines under invalidation are fenced off from lookups and fills
    assign lk_fenced   = sd_busy && (lk_vpn[VPN_W-1:LINE_SHIFT] == sd_line);
    assign fill_fenced = sd_busy && (fill_vpn[VPN_W-1:LINE_SHIFT] == sd_line);
    assign lk_any      = (|lk_match) && !lk_fenced && !st_q.clr_busy;
    assign fill_ok     = fill_valid && !fill_fenced && !st_q.clr_busy;

    always_comb begin
        lk_sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_sel = lk_sel | st_q.data[i];
        end
    end

    always_comb begin
        st_d       = st_q;
        victim_adv = 1'b0;

        // lookup response and statistics pulses
        st_d.hit    = lk_valid && lk_any;
        st_d.s_hit  = lk_valid && lk_any;
        st_d.s_miss = lk_valid && !lk_any;
        st_d.entry  = (lk_valid && lk_any) ? lk_sel : '0;

        // one slot of the shoot-down scan per cycle
        if (sd_busy && (st_q.tag[sd_idx][VPN_W-1:LINE_SHIFT] == sd_line)) begin
            st_d.valid[sd_idx] = 1'b0;
        end

        // install from the walker
        if (fill_ok) begin
            if (|fill_match) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (fill_match[i]) st_d.data[i] = fill_entry;
                end
            end else begin
                st_d.valid[victim] = 1'b1;
                st_d.tag[victim]   = fill_vpn;
                st_d.data[victim]  = fill_entry;
                victim_adv         = 1'b1;
            end
        end

        // full clear occupies one cycle
        if (st_q.clr_busy) st_d.valid = '0;
        st_d.clr_busy = clr_start && !st_q.clr_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_hit    = st_q.hit;
    assign lk_entry  = st_q.entry;
    assign stat_hit  = st_q.s_hit;
    assign stat_miss = st_q.s_miss;
    assign clr_busy  = st_q.clr_busy;
endmodule

// File: rtl/tlb_shootdown_chk.sv
module tlb_shootdown_chk import tlb_pkg::*; #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ADDR_W  = 8,
    localparam int LINE_W = VPN_W - LINE_SHIFT,
    localparam int CNT_W  = $clog2(ENTRIES + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic              lk_hit,
    input logic              stat_hit,
    input logic              stat_miss,
    input logic              clr_start,
    input logic              clr_busy,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              sd_busy,
    input logic [LINE_W-1:0] sd_line
);
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_cnt <= '0;
        else if (sd_busy) busy_cnt <= busy_cnt + 1'b1;
        else              busy_cnt <= '0;
    end

    assert_one_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_hit && stat_miss));
    assert_lookup_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (stat_hit || stat_miss));
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(stat_hit || stat_miss));
    assert_sd_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(SD_OFFSET) && reg_wdata[SD_START_BIT] && !sd_busy)
        |=> sd_busy);
    assert_sd_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_busy) |-> (busy_cnt == CNT_W'(ENTRIES)));
    assert_line_fenced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && sd_busy && lk_vpn[VPN_W-1:LINE_SHIFT] == sd_line) |=> !lk_hit);
    assert_line_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_busy && reg_wr) |=> $stable(sd_line));
    assert_clr_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_start && !clr_busy) |=> clr_busy);
    assert_clr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |=> !clr_busy);
endmodule

bind tlb_shootdown tlb_shootdown_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
    .stat_hit(stat_hit), .stat_miss(stat_miss), .clr_start(clr_start), .clr_busy(clr_busy),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .sd_busy(sd_busy), .sd_line(sd_line)
);

// File: tb/tlb_shootdown_tb.sv
module tlb_shootdown_tb;
    localparam int ENTRIES = 16;
    localparam int VPN_W   = 20;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam logic [31:0] START = 32'h4000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_entry;
    logic              stat_hit, stat_miss;
    logic              fill_valid = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [DATA_W-1:0] fill_entry = '0;
    logic              clr_start = 1'b0;
    logic              clr_busy;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = 8'h18;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tlb_shootdown #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
        .lk_entry(lk_entry), .stat_hit(stat_hit), .stat_miss(stat_miss),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_entry(fill_entry),
        .clr_start(clr_start), .clr_busy(clr_busy), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic void chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endfunction

    // All tasks start and end just after a falling edge.
    function automatic logic [DATA_W-1:0] dat(logic [VPN_W-1:0] v);
        return {12'hA5C, v} ^ 32'h0000_1111;
    endfunction

    task automatic lookup(logic [VPN_W-1:0] v, bit exp_hit, logic [DATA_W-1:0] exp_d, string req);
        lk_valid = 1'b1; lk_vpn = v;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(lk_hit == exp_hit, req, $sformatf("hit vpn %0h", v), lk_hit, exp_hit);
        chk(stat_hit == exp_hit && stat_miss == !exp_hit, req, "stat pulse",
            {stat_hit, stat_miss}, {exp_hit, !exp_hit});
        chk(lk_entry == (exp_hit ? exp_d : '0), req, "entry", lk_entry, exp_hit ? exp_d : 0);
    endtask

    task automatic fill(logic [VPN_W-1:0] v, logic [DATA_W-1:0] d);
        fill_valid = 1'b1; fill_vpn = v; fill_entry = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic reg_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h18;
    endtask

    task automatic full_clear();
        clr_start = 1'b1;
        @(negedge clk);
        clr_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        #1;
        while (reg_rdata[31] && n < 100) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic t_reset();
        #1;
        chk(lk_hit == 0 && stat_hit == 0 && stat_miss == 0, "R1", "outputs", {lk_hit, stat_hit, stat_miss}, 0);
        chk(clr_busy == 0, "R1", "clr_busy", clr_busy, 0);
        chk(reg_rdata == 0, "R1", "readback", reg_rdata, 0);
        lookup(20'h00010, 0, 0, "R1");
    endtask

    task automatic t_basic();
        fill(20'h00010, dat(20'h00010));
        lookup(20'h00010, 1, dat(20'h00010), "R2");
        lookup(20'h00011, 0, 0, "R2");
        @(negedge clk);
        chk(!stat_hit && !stat_miss, "R2", "idle pulses", {stat_hit, stat_miss}, 0);
    endtask

    task automatic t_replace();
        full_clear();
        for (int i = 0; i < ENTRIES; i++) fill(20'h00100 + 20'(i), dat(20'h00100 + 20'(i)));
        fill(20'h00200, dat(20'h00200));
        lookup(20'h00100, 0, 0, "R3");
        lookup(20'h00101, 1, dat(20'h00101), "R3");
        lookup(20'h00200, 1, dat(20'h00200), "R3");
        fill(20'h00105, 32'hDEAD_0105);
        fill(20'h00201, dat(20'h00201));
        lookup(20'h00105, 1, 32'hDEAD_0105, "R4");
        lookup(20'h00101, 0, 0, "R4");
        lookup(20'h00102, 1, dat(20'h00102), "R4");
        lookup(20'h00201, 1, dat(20'h00201), "R4");
    endtask

    task automatic t_shoot();
        int n;
        full_clear();
        for (int i = 0; i < 6; i++) fill(20'h0003F + 20'(i), dat(20'h0003F + 20'(i)));
        reg_write(8'h18, START | 32'h41);
        #1;
        chk(reg_rdata[31] == 1'b1, "R5", "busy after start", reg_rdata[31], 1);
        chk(reg_rdata[VPN_W-1:0] == 20'h40, "R5", "aligned line", reg_rdata[VPN_W-1:0], 20'h40);
        wait_idle(n);
        chk(n == ENTRIES, "R5", "busy cycles", n, ENTRIES);
        for (int i = 0; i < 4; i++) lookup(20'h00040 + 20'(i), 0, 0, "R6");
        lookup(20'h0003F, 1, dat(20'h0003F), "R6");
        lookup(20'h00044, 1, dat(20'h00044), "R6");
    endtask

    task automatic t_during();
        int n;
        full_clear();
        fill(20'h00080, dat(20'h00080));
        fill(20'h00090, dat(20'h00090));
        reg_write(8'h18, START | 32'h80);
        lookup(20'h00080, 0, 0, "R7");
        lookup(20'h00090, 1, dat(20'h00090), "R7");
        fill(20'h00081, dat(20'h00081));
        fill(20'h000A0, dat(20'h000A0));
        reg_write(8'h18, START | 32'h90);
        reg_write(8'h1C, START | 32'h90);
        reg_write(8'h18, 32'h90);
        #1;
        chk(reg_rdata[VPN_W-1:0] == 20'h80, "R9", "line during busy", reg_rdata[VPN_W-1:0], 20'h80);
        wait_idle(n);
        chk(n == ENTRIES - 7, "R9", "remaining busy cycles", n, ENTRIES - 7);
        lookup(20'h00081, 0, 0, "R8");
        lookup(20'h000A0, 1, dat(20'h000A0), "R8");
        lookup(20'h00090, 1, dat(20'h00090), "R9");
        lookup(20'h00080, 0, 0, "R7");
        reg_write(8'h18, 32'h90);
        reg_write(8'h20, START | 32'h90);
        #1;
        chk(reg_rdata[31] == 0, "R9", "no start without bit30", reg_rdata[31], 0);
        chk(reg_rdata[VPN_W-1:0] == 20'h80, "R9", "line kept", reg_rdata[VPN_W-1:0], 20'h80);
        lookup(20'h00090, 1, dat(20'h00090), "R9");
    endtask

    task automatic t_clear();
        fill(20'h00300, dat(20'h00300));
        fill(20'h00301, dat(20'h00301));
        lookup(20'h00300, 1, dat(20'h00300), "R10");
        clr_start = 1'b1;
        @(negedge clk);
        chk(clr_busy == 1, "R10", "clr_busy set", clr_busy, 1);
        lk_valid = 1'b1; lk_vpn = 20'h00300;
        fill_valid = 1'b1; fill_vpn = 20'h00302; fill_entry = dat(20'h00302);
        @(negedge clk);
        clr_start = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0;
        chk(lk_hit == 0 && stat_miss == 1, "R10", "lookup during clear", {lk_hit, stat_miss}, 1);
        chk(clr_busy == 0, "R10", "single cycle busy", clr_busy, 0);
        lookup(20'h00300, 0, 0, "R10");
        lookup(20'h00301, 0, 0, "R10");
        lookup(20'h00302, 0, 0, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_replace();
        t_shoot();
        t_during();
        t_clear();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule